// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block joins two 18-bit ports, called A and B, with one storage path in each direction. Each path can work in three ways. It can pass data straight through. It can keep the value it holds. It can capture its input when its strobe falls. A pass control chooses between straight-through and stored operation. The strobe is sampled by the system clock, so a falling edge is seen as a high-to-low change between two clock samples.

There are no real tri-state pins. Each side has an input vector, an output vector and an output-enable vector, and the system bus builds the tri-state driver from these. The enable for the A-to-B path is active high. The enable for the B-to-A path is active low. An active-low asynchronous reset clears both stored values and holds both enable vectors low while it is asserted.

The block can be built with a bus-hold option. When it is on, each port has a per-bit float mask. A floating bit reads the last value that was seen on that bit while it was driven.

Top module: `ubt_xcvr`

## Requirements
- R1: Data goes through each path without inversion, across the full `WIDTH`-bit word (18 bits by default).
- R2: While `ab_pass` is 1, `b_out` equals the effective A input in the same cycle. The stored value is reloaded on every clock edge at which `ab_pass` is sampled high.
- R3: While `ab_pass` is 0 and `ab_strobe` does not fall, the stored value and `b_out` stay unchanged, whatever `a_in` does.
- R4: When `ab_pass` is 0 and `ab_strobe` is sampled 1 at one clock edge and 0 at the next, the A input present at that second edge is stored. From that edge on, it appears on `b_out`.
- R5: `b_oe` is all ones when `ab_drive` is 1 and all zeros when `ab_drive` is 0.
- R6: The B-to-A path behaves the same way, using `ba_pass` and `ba_strobe`. `a_oe` is all ones when `ba_drive_n` is 0 and all zeros when `ba_drive_n` is 1.
- R7: While `rst_n` is 0, `a_oe` and `b_oe` are zero and both stored values are zero. After release, a path with pass low outputs zero.
- R8: If the pass control and the strobe are both first sampled low at the same edge (with the strobe high at the previous edge), the capture takes priority. The stored value is the input at that edge.
- R9: With `BUS_HOLD` set to 1, a bit whose float mask bit is 1 reads its last driven value. That value is kept in a per-bit register that resets to zero and updates only while the bit is driven.
- R10: Both paths can be enabled at once, and neither path changes the other's stored value or output.
- R11: A rising strobe edge never loads the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples strobes and updates storage |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| a_in | input | WIDTH | Value seen on the A bus |
| a_float | input | WIDTH | Per-bit mask: 1 marks an A bit that nobody drives |
| a_out | output | WIDTH | Data this block drives onto A |
| a_oe | output | WIDTH | Per-bit drive enable for A, active high |
| b_in | input | WIDTH | Value seen on the B bus |
| b_float | input | WIDTH | Per-bit mask: 1 marks a B bit that nobody drives |
| b_out | output | WIDTH | Data this block drives onto B |
| b_oe | output | WIDTH | Per-bit drive enable for B, active high |
| ab_pass | input | 1 | A-to-B pass control: 1 passes straight through, 0 selects stored operation |
| ab_strobe | input | 1 | A-to-B capture strobe; acts on its falling edge |
| ab_drive | input | 1 | A-to-B output enable, active high |
| ba_pass | input | 1 | B-to-A pass control |
| ba_strobe | input | 1 | B-to-A capture strobe; acts on its falling edge |
| ba_drive_n | input | 1 | B-to-A output enable, active low |

## Verification
The hardest case to reach is the priority case. Here the pass control and the strobe fall at the same clock sample, and the new input differs from the old stored value, so the capture path and the hold path give different results. The stimulus table sets up that case in order. First a transparent step leaves the strobe high. The next step drops both controls together and changes A. The bit-level bus-hold mix is reached in a similar way. A fully driven word is loaded first, and then a partial float mask is applied so that held and live bits land in one output word.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
   typedef enum logic [1:0] {
      ST_HOLD    = 2'd0,
      ST_PASS    = 2'd1,
      ST_CAPTURE = 2'd2
   } store_mode_e;
endpackage

// File: rtl/ubt_edge.sv
module ubt_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= strobe;
   end

   assign fall = prev_q & ~strobe;
endmodule

// File: rtl/ubt_store.sv
module ubt_store #(
   parameter int WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pass,
   input  logic             fall,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   import ubt_pkg::*;

   store_mode_e      mode;
   logic [WIDTH-1:0] q;

   always_comb begin
      if (fall)      mode = ST_CAPTURE;
      else if (pass) mode = ST_PASS;
      else           mode = ST_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else begin
         case (mode)
            ST_CAPTURE: q <= din;
            ST_PASS:    q <= din;
            default:    q <= q;
         endcase
      end
   end

   assign dout = pass ? din : q;

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!pass && !fall) |=> $stable(q));
   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> (q == $past(din)));
   p_pass_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pass |=> (q == $past(din)));
endmodule

// File: rtl/ubt_hold.sv
module ubt_hold #(
   parameter int WIDTH   = 18,
   parameter bit ENABLE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin,
   input  logic [WIDTH-1:0] float_mask,
   output logic [WIDTH-1:0] eff
);
   generate
      if (ENABLE) begin : g_keep
         logic [WIDTH-1:0] held_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held_q <= '0;
            else        held_q <= (pin & ~float_mask) | (held_q & float_mask);
         end

         assign eff = (pin & ~float_mask) | (held_q & float_mask);

         p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (((held_q ^ $past(held_q)) & $past(float_mask)) == '0));
      end else begin : g_plain
         assign eff = pin & ~float_mask;
      end
   endgenerate
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
   parameter int WIDTH    = 18,
   parameter bit BUS_HOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] a_float,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_in,
   input  logic [WIDTH-1:0] b_float,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe,
   input  logic             ab_pass,
   input  logic             ab_strobe,
   input  logic             ab_drive,
   input  logic             ba_pass,
   input  logic             ba_strobe,
   input  logic             ba_drive_n
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ubt_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] a_eff, b_eff;
   logic             ab_fall, ba_fall;

   ubt_hold #(.WIDTH(WIDTH), .ENABLE(BUS_HOLD)) u_hold_a (
      .clk(clk), .rst_n(rst_n), .pin(a_in), .float_mask(a_float), .eff(a_eff));
   ubt_hold #(.WIDTH(WIDTH), .ENABLE(BUS_HOLD)) u_hold_b (
      .clk(clk), .rst_n(rst_n), .pin(b_in), .float_mask(b_float), .eff(b_eff));

   ubt_edge u_edge_ab (.clk(clk), .rst_n(rst_n), .strobe(ab_strobe), .fall(ab_fall));
   ubt_edge u_edge_ba (.clk(clk), .rst_n(rst_n), .strobe(ba_strobe), .fall(ba_fall));

   ubt_store #(.WIDTH(WIDTH)) u_store_ab (
      .clk(clk), .rst_n(rst_n), .pass(ab_pass), .fall(ab_fall),
      .din(a_eff), .dout(b_out));
   ubt_store #(.WIDTH(WIDTH)) u_store_ba (
      .clk(clk), .rst_n(rst_n), .pass(ba_pass), .fall(ba_fall),
      .din(b_eff), .dout(a_out));

   assign b_oe = {WIDTH{ab_drive & rst_n}};
   assign a_oe = {WIDTH{~ba_drive_n & rst_n}};

   always_comb begin
      if (!rst_n) begin
         p_quiet_reset_r7: assert ((a_oe == '0) && (b_oe == '0));
      end
   end

   p_b_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ab_drive |-> (b_oe == {WIDTH{1'b1}}));
   p_a_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ba_drive_n |-> (a_oe == '0));
endmodule

// File: tb/tb_ubt_xcvr.sv
module tb_ubt_xcvr;
   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, a_float = '0, b_in = '0, b_float = '0;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;
   logic         ab_pass = 1'b0, ab_strobe = 1'b0, ab_drive = 1'b0;
   logic         ba_pass = 1'b0, ba_strobe = 1'b0, ba_drive_n = 1'b1;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ubt_xcvr #(.WIDTH(W), .BUS_HOLD(1'b1)) dut (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_in), .a_float(a_float), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_float(b_float), .b_out(b_out), .b_oe(b_oe),
      .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
      .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n));

   // entry: {pass, strobe, a value, expected b_out after the edge}
   typedef struct packed {
      logic         pass;
      logic         strobe;
      logic [W-1:0] a;
      logic [W-1:0] exp;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 18'h12345, 18'h12345},  // R2 straight-through
      '{1'b1, 1'b0, 18'h3FFFF, 18'h3FFFF},  // R1 all bits, no inversion
      '{1'b0, 1'b0, 18'h00001, 18'h3FFFF},  // R3 hold
      '{1'b0, 1'b1, 18'h00002, 18'h3FFFF},  // R11 rising edge ignored
      '{1'b0, 1'b1, 18'h00003, 18'h3FFFF},  // R3 strobe steady high
      '{1'b0, 1'b0, 18'h2AAAA, 18'h2AAAA},  // R4 falling-edge capture
      '{1'b0, 1'b0, 18'h15555, 18'h2AAAA},  // R3 strobe steady low
      '{1'b1, 1'b1, 18'h15555, 18'h15555},  // R2 pass with strobe high
      '{1'b0, 1'b0, 18'h0F0F0, 18'h0F0F0},  // R8 pass and strobe fall together
      '{1'b0, 1'b0, 18'h00000, 18'h0F0F0}   // R8 value retained
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      // R7: reset with both enables requested
      ab_drive = 1'b1;
      ba_drive_n = 1'b0;
      #12;
      chk("R7 b_oe in reset", b_oe, '0);
      chk("R7 a_oe in reset", a_oe, '0);
      chk("R7 b_out stored zero", b_out, '0);
      chk("R7 a_out stored zero", a_out, '0);
      @(negedge clk);
      rst_n = 1'b1;
      ba_drive_n = 1'b1;
      step();
      chk("R5 b_oe enabled", b_oe, {W{1'b1}});
      chk("R6 a_oe disabled", a_oe, '0);

      // table walk on the A-to-B path
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ab_pass   = VECS[i].pass;
         ab_strobe = VECS[i].strobe;
         a_in      = VECS[i].a;
         step();
         chk($sformatf("R1-table step %0d", i), b_out, VECS[i].exp);
      end

      // R5: disable
      @(negedge clk);
      ab_drive = 1'b0;
      #1;
      chk("R5 b_oe disabled", b_oe, '0);

      // R6: B-to-A mirror, straight-through then capture
      @(negedge clk);
      ba_drive_n = 1'b0;
      ba_pass = 1'b1;
      ba_strobe = 1'b1;
      b_in = 18'h1ABCD;
      step();
      chk("R6 a_out straight-through", a_out, 18'h1ABCD);
      chk("R6 a_oe enabled", a_oe, {W{1'b1}});
      @(negedge clk);
      ba_pass = 1'b0;
      b_in = 18'h00777;
      step();
      chk("R6 a_out held", a_out, 18'h1ABCD);
      @(negedge clk);
      ba_strobe = 1'b0;
      b_in = 18'h2468A;
      step();
      chk("R6 a_out capture", a_out, 18'h2468A);

      // R10: both directions enabled at once
      @(negedge clk);
      ab_drive = 1'b1;
      ab_pass = 1'b1;
      a_in = 18'h11111;
      b_in = 18'h22222;
      step();
      chk("R10 b_out", b_out, 18'h11111);
      chk("R10 a_out unchanged", a_out, 18'h2468A);
      chk("R10 both enables", a_oe & b_oe, {W{1'b1}});

      // R9: bus hold
      @(negedge clk);
      a_in = 18'h33333;
      a_float = '0;
      step();
      @(negedge clk);
      a_float = {W{1'b1}};
      a_in = 18'h00000;
      step();
      chk("R9 fully floating keeps last", b_out, 18'h33333);
      @(negedge clk);
      a_float = 18'h000FF;
      a_in = 18'h3FF00;
      step();
      chk("R9 mixed held and live bits", b_out, 18'h3FF33);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule